// File: doc/BRIEF.md
# Clear-on-Read Modem Status Byte with Interrupt

This block keeps the 8-bit status byte of a serial modem controller and drives its interrupt line. It takes single-cycle event pulses from three sources:

- the transmitter, which reports that its data buffer is empty and that it has gone idle;
- the receiver, which reports that a byte is ready and supplies a checksum verdict;
- the pattern detector, which reports three independent match events.

Each event sets a sticky flag. The checksum verdict is different: it is latched as a level whenever the receiver presents a fresh result.

The interrupt line is active high. It is the OR of two groups. The three pattern-match flags always count. The three data-path flags count only when their enable bit is set. The checksum bit never interrupts.

A host reads the byte with a one-cycle read strobe. The byte seen during the strobe cycle is the value held before the clear. At the following edge every flag drops, and so does the interrupt, except for events that arrive in the same cycle as the strobe: those are kept for the next read.

Top module: `modem_status_irq`

## Requirements
- R1: After reset, status_o is 8'h00 and irq_o is 0.
- R2: status_o[7] is always 0.
- R3: When chk_upd_i is high, status_o[6] takes chk_ok_i at the next edge (1 = checksum correct). Otherwise it holds its value until a read clears it.
- R4: A high evt_i[k] for k in 3..5 sets status_o[k] at the next edge. Bit 3 is transmit buffer empty, bit 4 is receive byte ready, bit 5 is transmitter idle. The bit stays set until a read.
- R5: A high evt_i[k] for k in 0..2 sets status_o[k] at the next edge and the bit stays set until a read. Bit 2 is the programmable-word match and bits 1 and 0 are the two fixed-pattern matches.
- R6: irq_o equals (status_o[2] | status_o[1] | status_o[0]) | OR over j of (status_o[3+j] & irq_en_i[j]). Bit 6 never drives irq_o.
- R7: In a cycle with rd_i high, status_o shows the pre-clear value. At the next edge all bits 0..6 clear, and irq_o falls if no new event arrives.
- R8: An evt_i bit that is high in the same cycle as rd_i leaves its flag set after the clear.
- R9: A chk_upd_i that is high in the same cycle as rd_i leaves status_o[6] equal to chk_ok_i after the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Event pulses; bit k sets status bit k |
| chk_upd_i | input | 1 | Fresh checksum verdict is present |
| chk_ok_i | input | 1 | Checksum verdict, 1 = correct |
| irq_en_i | input | 3 | Interrupt enables for status bits 3, 4, 5 |
| rd_i | input | 1 | Host read strobe; clears at the next edge |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The colliding case is a host read landing in the same cycle as new events or a checksum update: the clear and the set compete for the same flop. The bench sweeps all 64 event patterns under all 8 enable settings, and every pattern is applied once alone and once together with a read strobe. A cycle-level model built from the requirements judges each cycle: the status byte must show the pre-clear value during the strobe, only the coincident events may survive, and irq_o must follow the surviving flags and the enables.

// File: rtl/modem_status_pkg.sv
package modem_status_pkg;
  localparam int unsigned N_MATCH  = 3;                 // bits 0..2, unmaskable
  localparam int unsigned N_MASK   = 3;                 // bits 3..5, maskable
  localparam int unsigned N_EVT    = N_MATCH + N_MASK;
  localparam int unsigned CHK_BIT  = N_EVT;             // bit 6
  localparam int unsigned STAT_W   = N_EVT + 2;         // plus checksum and zero bit
endpackage

// File: rtl/evt_flag.sv
module evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);  // set beats clear
  end

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  // R4
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/chk_latch.sv
module chk_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic val_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (upd_i) q_o <= val_i;
    else if (clr_i) q_o <= 1'b0;
  end

  // R9
  upd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (q_o == $past(val_i)));
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned N_MATCH = 3,
  parameter int unsigned N_MASK  = 3
) (
  input  logic [N_MATCH-1:0] match_i,
  input  logic [N_MASK-1:0]  mask_flag_i,
  input  logic [N_MASK-1:0]  en_i,
  output logic               irq_o
);
  always_comb irq_o = (|match_i) | (|(mask_flag_i & en_i));
endmodule

// File: rtl/modem_status_irq.sv
module modem_status_irq
  import modem_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              chk_upd_i,
  input  logic              chk_ok_i,
  input  logic [N_MASK-1:0] irq_en_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [N_EVT-1:0] flag_q;
  logic             chk_q;

  for (genvar k = 0; k < N_EVT; k++) begin : g_flag
    evt_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i[k]),
      .clr_i  (rd_i),
      .q_o    (flag_q[k])
    );
  end

  chk_latch u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (chk_upd_i),
    .val_i  (chk_ok_i),
    .clr_i  (rd_i),
    .q_o    (chk_q)
  );

  irq_merge #(.N_MATCH(N_MATCH), .N_MASK(N_MASK)) u_irq (
    .match_i     (flag_q[N_MATCH-1:0]),
    .mask_flag_i (flag_q[N_EVT-1:N_MATCH]),
    .en_i        (irq_en_i),
    .irq_o       (irq_o)
  );

  assign status_o = {1'b0, chk_q, flag_q};

  // R7
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && evt_i == '0 && !chk_upd_i) |=> (status_o == '0 && !irq_o));
  // R5
  match_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i[N_MATCH-1:0]) |=> irq_o);
  // R1
  always_comb if (!rst_ni) reset_chk: assert (status_o == '0 && !irq_o);
endmodule

// File: tb/modem_status_irq_test.sv
module modem_status_irq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] evt_i = '0;
  logic       chk_upd_i = 1'b0, chk_ok_i = 1'b0, rd_i = 1'b0;
  logic [2:0] irq_en_i = '0;
  logic [7:0] status_o;
  logic       irq_o;

  int checks = 0, errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [6:0] exp_q = '0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  modem_status_irq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .chk_upd_i(chk_upd_i),
    .chk_ok_i(chk_ok_i), .irq_en_i(irq_en_i), .rd_i(rd_i),
    .status_o(status_o), .irq_o(irq_o));

  function automatic logic exp_irq(input logic [6:0] q, input logic [2:0] en);
    return (|q[2:0]) | (|(q[5:3] & en));  // R6
  endfunction

  task automatic check(input string tag);
    checks++;
    if (status_o !== {1'b0, exp_q}) begin
      errors++;
      $display("FAIL %s status act=%h exp=%h", tag, status_o, {1'b0, exp_q});
    end
    checks++;
    if (irq_o !== exp_irq(exp_q, irq_en_i)) begin
      errors++;
      $display("FAIL R6 %s irq act=%b exp=%b", tag, irq_o, exp_irq(exp_q, irq_en_i));
    end
  endtask

  // apply inputs at negedge, check pre-edge outputs, then advance model
  task automatic step(input logic [5:0] e, input logic cu, input logic ck,
                      input logic rd, input string tag);
    @(negedge clk_i);
    evt_i = e; chk_upd_i = cu; chk_ok_i = ck; rd_i = rd;
    #1 check(tag);  // R7: during strobe, pre-clear value
    @(posedge clk_i);
    exp_q[5:0] = (rd ? 6'd0 : exp_q[5:0]) | e;  // R4 R5 R8
    exp_q[6]   = cu ? ck : (rd ? 1'b0 : exp_q[6]);  // R3 R9
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1 check("R1");
    rst_ni = 1'b1;
    for (int en = 0; en < 8; en++) begin
      irq_en_i = en[2:0];
      for (int p = 0; p < 64; p++) begin
        step(p[5:0], p[0], p[1], 1'b0, "R4 R5 R3");
        step(6'd0, 1'b0, 1'b0, 1'b0, "R4 R5 R3 hold");
        step(~p[5:0], p[2], p[3], 1'b1, "R7 R8 R9");
        step(6'd0, 1'b0, 1'b0, 1'b1, "R7 clear");
        @(negedge clk_i); #1;
        checks++;
        if (status_o[7] !== 1'b0) begin
          errors++;
          $display("FAIL R2 bit7 act=%b exp=0", status_o[7]);
        end
      end
    end
    step(6'd0, 1'b0, 1'b0, 1'b0, "R7 final");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule